// File: doc/BRIEF.md
# Repeated-Addition Sequential Multiplier

This block multiplies two unsigned operands by adding the multiplicand into an accumulator once for each unit of the multiplier. A down-counter tracks how many additions remain. A small controller steps through four states: waiting, zero shortcut, operand capture and accumulation. The datapath has one adder, one decrementer and three registers.

The caller waits for `ready`, presents both operands and raises `start` for a clock. The operands must stay unchanged for one further cycle, because they are captured in the cycle after the start is accepted. After that the inputs may change freely.

When `ready` returns high, `product` holds the result. It keeps that value until the next accepted start. The time taken depends on the data: a nonzero request takes the multiplier value plus two cycles. A request with a zero operand goes through the shortcut state and finishes in two cycles.

Top module: `repadd_mul`

## Requirements
- R1: A clock edge with `rst_n` low returns the block to the waiting state, even in the middle of an operation. After that edge, `ready` is 1 and `product` is 0.
- R2: A start accepted with both operands nonzero yields `product` = `op_a` × `op_b`. `ready` comes back high exactly `op_b` + 2 clock edges after the accepting edge.
- R3: `ready` is high only while waiting. It drops on the edge that accepts a start and stays low until the operation completes.
- R4: A start accepted with either operand equal to 0 gives `product` = 0. `ready` is low for exactly one cycle.
- R5: In a nonzero operation, the capture cycle clears `product` to 0. After that, each accumulation cycle adds the captured multiplicand to `product` and lowers the remaining count by one, both in the same cycle.
- R6: `start` seen while `ready` is low has no effect on the running operation. This includes the last accumulation cycle.
- R7: Operands are captured on the edge after the accepting edge. Later changes on `op_a` and `op_b` do not alter the result.
- R8: While waiting without a start, `product` keeps its value whatever the operand inputs do.
- R9: The full-scale case 255 × 255 gives 65025 without overflow, after 257 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiplication; taken only while `ready` is high |
| op_a | input | A_W (8) | Unsigned multiplicand |
| op_b | input | B_W (8) | Unsigned multiplier, also the number of additions |
| product | output | P_W (16) | Unsigned result register |
| ready | output | 1 | High while waiting for a request |

## Verification
Three things can happen in the same cycle: the last accumulation, the return of `ready`, and a `start` that is already high. The bench holds `start` high through a whole operation. It then leaves `start` high, with new operands, into the first waiting cycle. It also raises `start` in the middle of a long accumulation. A behavioural model, driven only by the requirement formulas, predicts `ready` and `product` on every cycle. The per-cycle comparison therefore shows whether a start was wrongly taken during the run or wrongly missed at its end. Operand scrambling after capture, and a reset in the middle of an operation, are judged the same way.

// File: rtl/repadd_pkg.sv
// Shared definitions for the repeated-addition multiplier.
// Assumes: nothing beyond standard SystemVerilog packages.
package repadd_pkg;
    // Controller states: wait, zero shortcut, operand capture, accumulate.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ZERO = 2'd1,
        ST_LOAD = 2'd2,
        ST_OP   = 2'd3
    } mul_state_t;
endpackage

// File: rtl/repadd_ctrl.sv
// Sequencing FSM of the multiplier.
// Accepts a start only while waiting. Chooses the zero shortcut or the
// capture/accumulate path, and ends the accumulation when the datapath
// reports its final pass.
// Assumes: opnd_zero and last_pass come combinationally from the datapath.
module repadd_ctrl
    import repadd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic opnd_zero,
    input  logic last_pass,
    output logic ready,
    output logic capture,
    output logic accumulate
);
    mul_state_t state_q, state_d;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start) state_d = opnd_zero ? ST_ZERO : ST_LOAD;
            ST_ZERO: state_d = ST_IDLE;
            ST_LOAD: state_d = ST_OP;
            ST_OP:   if (last_pass) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Decoded controls toward the datapath and the port.
    always_comb begin
        ready      = (state_q == ST_IDLE);
        capture    = (state_q == ST_ZERO) || (state_q == ST_LOAD);
        accumulate = (state_q == ST_OP);
    end

    // Accepted start leaves the waiting state on the next edge.
    assert_start_leaves_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start) |=> !ready);
    // Final pass of accumulation returns to waiting.
    assert_last_pass_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accumulate && last_pass) |=> ready);
    // Zero shortcut: one capture cycle, then ready again.
    assert_zero_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start && opnd_zero) |=> (capture && !accumulate) ##1 ready);
    // While busy, a start never causes an extra capture cycle.
    assert_busy_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accumulate && !last_pass && start) |=> accumulate);
endmodule

// File: rtl/repadd_path.sv
// Datapath of the multiplier: multiplicand, remaining-count and product
// registers, one adder, one decrementer and the zero detectors.
// Assumes: capture and accumulate are never high together.
module repadd_path #(
    parameter int A_W = 8,
    parameter int B_W = 8,
    parameter int P_W = A_W + B_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] op_a,
    input  logic [B_W-1:0] op_b,
    input  logic           capture,
    input  logic           accumulate,
    output logic [P_W-1:0] product,
    output logic           opnd_zero,
    output logic           last_pass
);
    localparam logic [B_W-1:0] CNT_ONE = B_W'(1);

    logic [A_W-1:0] mcand_q;
    logic [B_W-1:0] count_q;
    logic [P_W-1:0] acc_q;

    // Zero detection on the live operands and the final-pass flag.
    always_comb begin
        opnd_zero = (op_a == '0) || (op_b == '0);
        last_pass = (count_q == CNT_ONE);
        product   = acc_q;
    end

    // Register transfers: capture loads and clears, accumulate adds and counts down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            count_q <= '0;
            acc_q   <= '0;
        end else if (capture) begin
            mcand_q <= op_a;
            count_q <= op_b;
            acc_q   <= '0;
        end else if (accumulate) begin
            acc_q   <= acc_q + P_W'(mcand_q);
            count_q <= count_q - CNT_ONE;
        end
    end

    // Each accumulation cycle adds the held multiplicand.
    assert_accum_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accumulate |=> acc_q == $past(acc_q) + P_W'($past(mcand_q)));
    // Each accumulation cycle lowers the count by one.
    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accumulate |=> count_q == $past(count_q) - CNT_ONE);
    // The count never reaches zero while accumulating.
    assert_count_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accumulate |-> count_q != '0);
    // Capture always clears the product.
    assert_capture_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> acc_q == '0);
endmodule

// File: rtl/repadd_mul.sv
// Top of the repeated-addition multiplier: connects the controller and
// the datapath.
// Assumes: operands are held for one cycle after an accepted start.
module repadd_mul #(
    parameter int A_W = 8,
    parameter int B_W = 8,
    parameter int P_W = A_W + B_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [A_W-1:0] op_a,
    input  logic [B_W-1:0] op_b,
    output logic [P_W-1:0] product,
    output logic           ready
);
    logic capture, accumulate, opnd_zero, last_pass;

    repadd_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .opnd_zero  (opnd_zero),
        .last_pass  (last_pass),
        .ready      (ready),
        .capture    (capture),
        .accumulate (accumulate)
    );

    repadd_path #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_a       (op_a),
        .op_b       (op_b),
        .capture    (capture),
        .accumulate (accumulate),
        .product    (product),
        .opnd_zero  (opnd_zero),
        .last_pass  (last_pass)
    );

    // While waiting without a start, the result stays put.
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> $stable(product));
endmodule

// File: tb/test_repadd_mul.sv
`timescale 1ns/1ps
module test_repadd_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  op_a = '0;
    logic [7:0]  op_b = '0;
    logic [15:0] product;
    logic        ready;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    string cur_tag = "R1";

    // Behavioural reference state.
    int busy = 0, e = 0, ma = 0, mb = 0, zro = 0;
    int exp_prod = 0, exp_ready = 1;
    bit live = 0;

    always #2.5 clk = ~clk;

    repadd_mul i_repadd_mul (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_a(op_a), .op_b(op_b), .product(product), .ready(ready)
    );

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // Reference: timing is derived from elapsed edges since the accepting edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            busy = 0; exp_prod = 0; exp_ready = 1;
        end else if (busy == 0) begin
            if (start) begin
                busy = 1; e = 0; ma = int'(op_a); mb = int'(op_b);
                zro = (ma == 0 || mb == 0) ? 1 : 0;
                exp_ready = 0;
            end
        end else begin
            e++;
            if (zro != 0) begin
                exp_prod = 0; exp_ready = 1; busy = 0;
            end else if (e == 1) begin
                exp_prod = 0;
            end else begin
                exp_prod = (exp_prod + ma) % 65536;
                if (e == mb + 1) begin exp_ready = 1; busy = 0; end
            end
        end
    end

    // Per-cycle comparison away from the active edge, plus the watchdog.
    always @(negedge clk) begin
        cycles++;
        if (live) begin
            chk({cur_tag, " ready (R3)"}, int'(ready), exp_ready);
            chk({cur_tag, " product"}, int'(product), exp_prod);
        end
        if (cycles > 100000) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    // One multiplication with start pulsed for a single cycle.
    task automatic run_mul(int a, int b, string tag, bit scramble);
        int lat;
        @(negedge clk);
        cur_tag = tag; op_a = 8'(a); op_b = 8'(b); start = 1'b1;
        @(negedge clk);
        start = 1'b0; lat = 1;
        if (scramble) begin
            @(negedge clk); lat++;
            op_a = 8'(a ^ 8'hA5); op_b = 8'(b ^ 8'h3C);
        end
        while (!ready && lat < 1000) begin @(negedge clk); lat++; end
        chk({tag, " latency"}, lat, (a == 0 || b == 0) ? 2 : b + 2);
        chk({tag, " result"}, int'(product), a * b);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        live = 1;
        // R1: reset state
        chk("R1 reset ready", int'(ready), 1);
        chk("R1 reset product", int'(product), 0);
        rst_n = 1'b1;

        run_mul(7, 5, "R2 7x5", 0);
        run_mul(1, 1, "R2 1x1", 0);
        run_mul(255, 1, "R2 255x1", 0);
        run_mul(1, 255, "R5 1x255", 0);
        run_mul(13, 200, "R5 13x200", 0);

        run_mul(0, 9, "R4 0x9", 0);
        run_mul(9, 7, "R2 9x7", 0);
        run_mul(9, 0, "R4 9x0", 0);
        run_mul(0, 0, "R4 0x0", 0);

        // R7: operands changed after capture must not matter.
        run_mul(11, 17, "R7 scramble", 1);

        // R8: idle with moving operands, no start.
        cur_tag = "R8 idle";
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); op_a = 8'(i * 37); op_b = 8'(i * 11 + 1);
        end
        chk("R8 held product", int'(product), 11 * 17);

        // R6: start raised mid-operation with other operands.
        begin
            int lat;
            @(negedge clk); cur_tag = "R6 mid-start";
            op_a = 8'd20; op_b = 8'd30; start = 1'b1;
            @(negedge clk); start = 1'b0; lat = 1;
            @(negedge clk); lat++;
            repeat (10) @(negedge clk);
            lat += 10;
            op_a = 8'd3; op_b = 8'd4; start = 1'b1;
            repeat (3) @(negedge clk);
            lat += 3;
            start = 1'b0;
            while (!ready && lat < 1000) begin @(negedge clk); lat++; end
            chk("R6 latency", lat, 32);
            chk("R6 result", int'(product), 600);
        end

        // R6: start held through the last pass and into the first waiting cycle.
        begin
            int lat;
            @(negedge clk); cur_tag = "R6 held-start";
            op_a = 8'd6; op_b = 8'd4; start = 1'b1; lat = 0;
            do begin @(negedge clk); lat++; end while (!ready && lat < 1000);
            chk("R6 held latency", lat, 6);
            chk("R6 held result", int'(product), 24);
            op_a = 8'd5; op_b = 8'd3;
            @(negedge clk); start = 1'b0;
            chk("R6 restart taken (R3)", int'(ready), 0);
            lat = 1;
            while (!ready && lat < 1000) begin @(negedge clk); lat++; end
            chk("R6 restart latency", lat, 5);
            chk("R6 restart result", int'(product), 15);
        end

        // R9: full scale.
        run_mul(255, 255, "R9 255x255", 0);

        // R1: reset in the middle of an operation.
        @(negedge clk); cur_tag = "R1 mid-reset";
        op_a = 8'd40; op_b = 8'd50; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (8) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid ready", int'(ready), 1);
        chk("R1 mid product", int'(product), 0);
        rst_n = 1'b1;
        run_mul(12, 12, "R2 after reset", 0);

        live = 0;
        finish_run();
    end
endmodule